// File: doc/BRIEF.md
# Upper Memory Window Bank Mapper

This block turns a CPU access that falls in the top 12 KB of a 64 KB address space into a physical offset inside a 128 KB RAM image. Inside that window the lowest 4 KB can be either of two banks, picked by a bank-select control. The 8 KB above it is shared by both banks. A second 64 KB image can stand in for the first. It is used for auxiliary accesses, and for main accesses when the alternate-page control is set. A separate fixed path serves a 16 KB region of the second image. In that path, address bit 12 is inverted whenever bit 13 is set.

The block has one register stage. An access presented on one rising edge shows up on the outputs after that edge. The outputs are the physical address, a valid flag that follows the request, and a write-permitted flag. The write flag stays low for window writes while the write-enable control is clear, so the RAM throws those writes away. Reads never depend on write-enable. The RAM and the soft-switch registers that drive the controls sit outside this block.

Top module: `upper_ram_mapper`

## Requirements
- R1: While rst_ni is low, valid_o, wr_ok_o and addr_o are all zero.
- R2: Outputs update on the rising edge after an access is presented. An edge with req_i low leaves valid_o and wr_ok_o low. An edge with req_i high sets valid_o.
- R3: Region code 2'b00 is the main window, 2'b01 is the auxiliary window, 2'b10 is the fixed region and 2'b11 behaves as 2'b01.
- R4: In a window region with offset below 0x1000 and bank_sel_i high, addr_o[15:0] is 0xC000 plus the offset's low 12 bits.
- R5: In a window region with offset below 0x1000 and bank_sel_i low, addr_o[15:0] is 0xD000 plus the offset's low 12 bits.
- R6: In a window region with offset 0x1000 or above, addr_o[15:0] is 0xE000 plus the offset's low 13 bits, and bank_sel_i has no effect.
- R7: addr_o[16] is set for the auxiliary window, and for the main window only when alt_img_i is high.
- R8: In a window region, wr_ok_o is high only for a request with we_i high and wr_en_i high. A write with wr_en_i low still produces valid_o and the same address as a read.
- R9: In the fixed region, addr_o is 0x1C000 plus the offset, after bit 12 of the offset is inverted whenever bit 13 is set. bank_sel_i and alt_img_i have no effect there.
- R10: In the fixed region, wr_ok_o follows we_i for a request, whatever the value of wr_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access present this cycle |
| we_i | input | 1 | Access is a write |
| region_i | input | 2 | Region code (see R3) |
| off_i | input | 14 | Offset within the region |
| bank_sel_i | input | 1 | High selects the 0xC000 bank for the lower 4 KB |
| wr_en_i | input | 1 | Window write enable |
| alt_img_i | input | 1 | Main window uses the upper 64 KB image |
| valid_o | output | 1 | Registered request |
| wr_ok_o | output | 1 | Registered write permission |
| addr_o | output | 17 | Registered physical RAM offset |

## Verification
A mistake in the bank or image choice shows up as a wrong addr_o one edge after the access is presented. It appears in bit 16 or bits 15:12, depending on which choice went wrong. A broken bit swap in the fixed path changes only bit 12, and only when bit 13 of the offset is set. A permission fault shows up in the same cycle as a wr_ok_o that disagrees with we_i and wr_en_i. The sweep covers every offset under every control combination, so a single mismapped address is caught at the first access that uses it.

// File: rtl/upper_map_pkg.sv
package upper_map_pkg;
  localparam int OFF_W  = 14;
  localparam int ADDR_W = 17;

  typedef enum logic [1:0] {
    RGN_MAIN  = 2'b00,
    RGN_AUX   = 2'b01,
    RGN_FIXED = 2'b10,
    RGN_AUX2  = 2'b11
  } region_e;

  localparam logic [15:0] BANK_LO_C = 16'hC000;
  localparam logic [15:0] BANK_LO_D = 16'hD000;
  localparam logic [15:0] COMMON_B  = 16'hE000;
  localparam logic [15:0] FIXED_B   = 16'hC000;
endpackage

// File: rtl/upper_lc_xlate.sv
module upper_lc_xlate
  import upper_map_pkg::*;
#(
  parameter int OW = OFF_W,
  parameter int AW = ADDR_W
) (
  input  logic [OW-1:0] off_i,
  input  logic          bank_sel_i,
  input  logic          hi_img_i,
  output logic [AW-1:0] addr_o
);
  localparam int LO_W  = 12;
  localparam int COM_W = 13;

  logic        in_low;
  logic [15:0] base;
  logic [15:0] disp;

  assign in_low = (off_i < OW'(1 << LO_W));

  always_comb begin
    if (in_low) begin
      base = bank_sel_i ? BANK_LO_C : BANK_LO_D;
      disp = 16'(off_i[LO_W-1:0]);
    end else begin
      base = COMMON_B;
      disp = 16'(off_i[COM_W-1:0]);
    end
  end

  assign addr_o = {{(AW-17){1'b0}}, hi_img_i, base + disp};
endmodule

// File: rtl/upper_fixed_xlate.sv
module upper_fixed_xlate
  import upper_map_pkg::*;
#(
  parameter int OW = OFF_W,
  parameter int AW = ADDR_W
) (
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] addr_o
);
  logic [OW-1:0] swz;

  always_comb begin
    swz     = off_i;
    swz[12] = off_i[12] ^ off_i[13];
  end

  assign addr_o = {{(AW-17){1'b0}}, 1'b1, FIXED_B + 16'(swz)};
endmodule

// File: rtl/upper_map_oreg.sv
module upper_map_oreg #(
  parameter int AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_d,
  input  logic          wr_ok_d,
  input  logic [AW-1:0] addr_d,
  output logic          valid_q,
  output logic          wr_ok_q,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wr_ok_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      wr_ok_q <= wr_ok_d;
      addr_q  <= addr_d;
    end
  end
endmodule

// File: rtl/upper_ram_mapper.sv
module upper_ram_mapper
  import upper_map_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        region_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              bank_sel_i,
  input  logic              wr_en_i,
  input  logic              alt_img_i,
  output logic              valid_o,
  output logic              wr_ok_o,
  output logic [ADDR_W-1:0] addr_o
);
  region_e            rgn;
  logic               is_fixed;
  logic               hi_img;
  logic [ADDR_W-1:0]  lc_addr;
  logic [ADDR_W-1:0]  fx_addr;
  logic [ADDR_W-1:0]  addr_d;
  logic               wr_ok_d;

  assign rgn      = region_e'(region_i);
  assign is_fixed = (rgn == RGN_FIXED);
  assign hi_img   = (rgn == RGN_MAIN) ? alt_img_i : 1'b1;

  upper_lc_xlate #(.OW(OFF_W), .AW(ADDR_W)) u_lc (
    .off_i      (off_i),
    .bank_sel_i (bank_sel_i),
    .hi_img_i   (hi_img),
    .addr_o     (lc_addr)
  );

  upper_fixed_xlate #(.OW(OFF_W), .AW(ADDR_W)) u_fx (
    .off_i  (off_i),
    .addr_o (fx_addr)
  );

  assign addr_d  = is_fixed ? fx_addr : lc_addr;
  // fixed path ignores the window write enable
  assign wr_ok_d = req_i && we_i && (is_fixed || wr_en_i);

  upper_map_oreg #(.AW(ADDR_W)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_d (req_i),
    .wr_ok_d (wr_ok_d),
    .addr_d  (addr_d),
    .valid_q (valid_o),
    .wr_ok_q (wr_ok_o),
    .addr_q  (addr_o)
  );
endmodule

// File: rtl/upper_ram_mapper_chk.sv
module upper_ram_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  region_i,
  input logic [13:0] off_i,
  input logic        bank_sel_i,
  input logic        wr_en_i,
  input logic        alt_img_i,
  input logic        valid_o,
  input logic        wr_ok_o,
  input logic [16:0] addr_o
);
  assert_wr_implies_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> valid_o);

  assert_idle_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !wr_ok_o));

  assert_bank_c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i != 2'b10 && off_i < 14'h1000 && bank_sel_i) |=> (addr_o[15:12] == 4'hC));

  assert_bank_d_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i != 2'b10 && off_i < 14'h1000 && !bank_sel_i) |=> (addr_o[15:12] == 4'hD));

  assert_common_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i != 2'b10 && off_i >= 14'h1000) |=> (addr_o[15:13] == 3'b111));

  assert_aux_image_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i[0]) |=> addr_o[16]);

  assert_main_image_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i == 2'b00) |=> (addr_o[16] == $past(alt_img_i)));

  assert_wr_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i != 2'b10 && !wr_en_i) |=> !wr_ok_o);

  assert_fixed_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i == 2'b10) |=> (addr_o[16:14] == 3'b111));

  assert_fixed_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region_i == 2'b10) |=> (wr_ok_o == $past(we_i)));

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (!valid_o && !wr_ok_o && addr_o == '0);
  end
endmodule

bind upper_ram_mapper upper_ram_mapper_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .region_i   (region_i),
  .off_i      (off_i),
  .bank_sel_i (bank_sel_i),
  .wr_en_i    (wr_en_i),
  .alt_img_i  (alt_img_i),
  .valid_o    (valid_o),
  .wr_ok_o    (wr_ok_o),
  .addr_o     (addr_o)
);

// File: tb/upper_ram_mapper_tb_top.sv
module upper_ram_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  region_i = 2'b00;
  logic [13:0] off_i = '0;
  logic        bank_sel_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        alt_img_i = 1'b0;
  logic        valid_o;
  logic        wr_ok_o;
  logic [16:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  upper_ram_mapper dut_i (.*);

  // {region, bank_sel, alt_img, wr_en, we, off, exp_addr, exp_wr}
  localparam int VW = 38;
  localparam int NV = 11;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0123, 17'h0C123, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0FFF, 17'h0DFFF, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h1000, 17'h0F000, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h2FFF, 17'h0EFFF, 1'b0},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 14'h0010, 17'h1C010, 1'b1},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0800, 17'h1D800, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000, 17'h1C000, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 14'h2000, 17'h1F000, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 14'h3ABC, 17'h1EABC, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 14'h1FFF, 17'h1FFFF, 1'b1},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 14'h1234, 17'h1D234, 1'b0}
  };

  function automatic logic [16:0] ref_addr(input logic [1:0] rg, input logic [13:0] off,
                                           input logic bs, input logic az);
    int a;
    int o;
    o = int'(off);
    if (rg == 2'b10) begin
      if ((o & 'h2000) != 0) o = o ^ 'h1000;
      a = 'h1C000 + o;
    end else begin
      if (o < 'h1000) a = (bs ? 'hC000 : 'hD000) + (o & 'hFFF);
      else            a = 'hE000 + (o & 'h1FFF);
      if (rg != 2'b00 || az) a = a + 'h10000;
    end
    return 17'(a);
  endfunction

  task automatic check(input string tag, input logic v, input logic w, input logic [16:0] a);
    n_chk++;
    if (valid_o !== v || wr_ok_o !== w || addr_o !== a) begin
      n_fail++;
      $display("FAIL %s: got valid=%b wr=%b addr=%h, expected valid=%b wr=%b addr=%h",
               tag, valid_o, wr_ok_o, addr_o, v, w, a);
    end
  endtask

  task automatic access(input logic rq, input logic [1:0] rg, input logic bs, input logic az,
                        input logic wen, input logic w, input logic [13:0] off);
    req_i = rq; region_i = rg; bank_sel_i = bs; alt_img_i = az;
    wr_en_i = wen; we_i = w; off_i = off;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state with a pending access on the inputs
    req_i = 1'b1; we_i = 1'b1; wr_en_i = 1'b1; off_i = 14'h0555;
    repeat (3) @(posedge clk_i);
    #1 check("R1 reset", 1'b0, 1'b0, 17'h0);
    req_i = 1'b0; we_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      access(1'b1, v[37:36], v[35], v[34], v[33], v[32], v[31:18]);
      check($sformatf("R3-R10 vector %0d", i), 1'b1, v[0], v[17:1]);
    end

    // R2: idle edge after a write drops valid and permission
    access(1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0042);
    check("R2 active", 1'b1, 1'b1, 17'h0D042);
    access(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0042);
    check("R2 idle", 1'b0, 1'b0, 17'h0D042);

    // R6: bank select has no effect on the common area
    access(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h1ABC);
    check("R6 bs=1", 1'b1, 1'b0, 17'h0FABC);
    access(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h1ABC);
    check("R6 bs=0", 1'b1, 1'b0, 17'h0FABC);

    // R8: write with enable clear keeps address and valid
    access(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0777);
    check("R8 blocked write", 1'b1, 1'b0, 17'h1C777);

    // R10: fixed region write with enable clear is still permitted
    access(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 14'h3001);
    check("R10 fixed write", 1'b1, 1'b1, 17'h1E001);

    // R3 R4 R5 R6 R7 R8: full window sweep under every image/bank/region combination
    for (int c = 0; c < 8; c++) begin
      for (int o = 0; o < 'h3000; o++) begin
        logic [13:0] off;
        logic [1:0]  rg;
        off = 14'(o);
        rg  = (c[2]) ? 2'd1 : 2'd0;
        if (c[2] && off[2]) rg = 2'd3;
        access(1'b1, rg, c[0], c[1], off[1], off[0], off);
        check("R4/R5/R6/R7/R8 sweep", 1'b1, off[0] & off[1], ref_addr(rg, off, c[0], c[1]));
      end
    end

    // R9 R10: fixed region sweep
    for (int o = 0; o < 'h4000; o++) begin
      logic [13:0] off;
      off = 14'(o);
      access(1'b1, 2'd2, off[2], off[3], off[1], off[0], off);
      check("R9/R10 sweep", 1'b1, off[0], ref_addr(2'd2, off, off[2], off[3]));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule